// File: doc/BRIEF.md
# Two-Street Traffic Light Controller with Parade Hold

This block runs the lights at a crossing of two streets, A and B, as a synchronous Moore controller. Each street has a traffic sensor input and a two-bit lamp output. The controller gives street A a green light while cars keep arriving on A. When A goes quiet it shows yellow to A and then gives B the green. B keeps the green while B has traffic. After that B gets yellow and A gets the green again.

Two small machines share the work. A mode machine records whether a parade is in progress, based on a request input and an end input. While the parade flag is set, a lights machine keeps street B on green whatever the B sensor shows. Both machines change state only on the rising clock edge. The lamp outputs come from registers, so no input has a combinational path to an output.

Top module: `traffic_parade_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is A green / B red (`light_a`=00, `light_b`=10) with parade mode off. The lamp encoding is green=00, yellow=01, red=10.
- R2: In the A-green phase, an edge with `sense_a`=1 keeps A green and B red.
- R3: In the A-green phase, an edge with `sense_a`=0 moves to A yellow / B red (`light_a`=01, `light_b`=10).
- R4: The A-yellow phase always moves to A red / B green (`light_a`=10, `light_b`=00) on the next edge, whatever the inputs.
- R5: In the B-green phase, an edge with `sense_b`=1 or with parade mode on keeps B green.
- R6: In the B-green phase, an edge with parade mode off and `sense_b`=0 moves to A red / B yellow (`light_b`=01). The B-yellow phase always returns to A green / B red on the next edge.
- R7: An edge with `parade_req`=1 and `parade_end`=0 turns parade mode on. An edge with `parade_end`=1 turns it off. With both low, the mode holds.
- R8: When `parade_req` and `parade_end` are both 1 at the same edge, the end wins and parade mode is off after that edge.
- R9: At every edge after reset, at least one street shows red, and each lamp output only ever carries 00, 01 or 10.
- R10: Over long random runs of sensor and parade inputs, both lamp outputs match a cycle-accurate reference of R1 to R8 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sense_a | input | 1 | Traffic present on street A |
| sense_b | input | 1 | Traffic present on street B |
| parade_req | input | 1 | Request to enter parade mode |
| parade_end | input | 1 | Request to leave parade mode (has priority) |
| light_a | output | 2 | Street A lamp: 00 green, 01 yellow, 10 red |
| light_b | output | 2 | Street B lamp: 00 green, 01 yellow, 10 red |

## Verification
The effect of sensor input on the lamps appears at the first rising edge after the input is driven. The effect of a parade request or end appears one edge later, because the mode flag is registered before the lights machine uses it. The bench drives every input on the falling edge and samples the lamps on the next falling edge. It compares each sample against its own model, which steps the mode flag and the phase once per edge in that same order. The parade scenarios check the extra edge of delay explicitly: a release lets B stay green for one more cycle before yellow appears.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int LAMP_W  = 2;
  localparam int PHASE_W = 2;

  typedef logic [LAMP_W-1:0] lamp_t;

  localparam lamp_t LAMP_GREEN  = 2'b00;
  localparam lamp_t LAMP_YELLOW = 2'b01;
  localparam lamp_t LAMP_RED    = 2'b10;

  // Binary phase code: bit 1 says street B owns the crossing, bit 0 says the
  // owning street is in its yellow interval.
  typedef enum logic [PHASE_W-1:0] {
    ST_A_GO   = 2'b00,
    ST_A_WARN = 2'b01,
    ST_B_GO   = 2'b10,
    ST_B_WARN = 2'b11
  } phase_t;

  function automatic lamp_t a_lamp_of(phase_t s);
    return {s[1], ~s[1] & s[0]};
  endfunction

  function automatic lamp_t b_lamp_of(phase_t s);
    return {~s[1], s[1] & s[0]};
  endfunction
endpackage

// File: rtl/parade_mode_fsm.sv
module parade_mode_fsm (
  input  logic clk,
  input  logic rst,
  input  logic parade_req,
  input  logic parade_end,
  output logic parade_on
);
  typedef enum logic {MODE_NORMAL = 1'b0, MODE_PARADE = 1'b1} mode_t;

  mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (parade_end)      mode_d = MODE_NORMAL;
    else if (parade_req) mode_d = MODE_PARADE;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_NORMAL;
    else     mode_q <= mode_d;
  end

  assign parade_on = (mode_q == MODE_PARADE);

  AST_END_WINS: assert property (@(posedge clk) disable iff (rst)
    parade_end |=> !parade_on); // R8
  AST_REQ_ENTERS: assert property (@(posedge clk) disable iff (rst)
    (parade_req && !parade_end) |=> parade_on); // R7
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!parade_req && !parade_end) |=> $stable(parade_on)); // R7
endmodule

// File: rtl/light_seq_fsm.sv
module light_seq_fsm
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sense_a,
  input  logic   sense_b,
  input  logic   hold_b,
  output phase_t phase_q,
  output phase_t phase_d
);
  always_comb begin
    unique case (phase_q)
      ST_A_GO:   phase_d = sense_a ? ST_A_GO : ST_A_WARN;
      ST_A_WARN: phase_d = ST_B_GO;
      ST_B_GO:   phase_d = (hold_b || sense_b) ? ST_B_GO : ST_B_WARN;
      ST_B_WARN: phase_d = ST_A_GO;
      default:   phase_d = ST_A_GO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= ST_A_GO;
    else     phase_q <= phase_d;
  end

  AST_PARADE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase_q == ST_B_GO && hold_b) |=> phase_q == ST_B_GO); // R5
  AST_A_WARN_ADV: assert property (@(posedge clk) disable iff (rst)
    (phase_q == ST_A_WARN) |=> phase_q == ST_B_GO); // R4
  AST_B_WARN_ADV: assert property (@(posedge clk) disable iff (rst)
    (phase_q == ST_B_WARN) |=> phase_q == ST_A_GO); // R6
endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase_d,
  output lamp_t  lamp_a_q,
  output lamp_t  lamp_b_q
);
  // The registers load the decode of the next phase, so the lamps change in
  // the same cycle as the phase register without any input-to-output path.
  always_ff @(posedge clk) begin
    if (rst) begin
      lamp_a_q <= a_lamp_of(ST_A_GO);
      lamp_b_q <= b_lamp_of(ST_A_GO);
    end else begin
      lamp_a_q <= a_lamp_of(phase_d);
      lamp_b_q <= b_lamp_of(phase_d);
    end
  end
endmodule

// File: rtl/traffic_parade_ctrl.sv
module traffic_parade_ctrl
  import tlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sense_a,
  input  logic       sense_b,
  input  logic       parade_req,
  input  logic       parade_end,
  output logic [1:0] light_a,
  output logic [1:0] light_b
);
  logic   parade_on;
  phase_t phase_q, phase_d;
  lamp_t  lamp_a_q, lamp_b_q;

  parade_mode_fsm u_mode (
    .clk        (clk),
    .rst        (rst),
    .parade_req (parade_req),
    .parade_end (parade_end),
    .parade_on  (parade_on)
  );

  light_seq_fsm u_seq (
    .clk     (clk),
    .rst     (rst),
    .sense_a (sense_a),
    .sense_b (sense_b),
    .hold_b  (parade_on),
    .phase_q (phase_q),
    .phase_d (phase_d)
  );

  lamp_decode u_lamp (
    .clk      (clk),
    .rst      (rst),
    .phase_d  (phase_d),
    .lamp_a_q (lamp_a_q),
    .lamp_b_q (lamp_b_q)
  );

  assign light_a = lamp_a_q;
  assign light_b = lamp_b_q;

  AST_ONE_SIDE_RED: assert property (@(posedge clk) disable iff (rst)
    (light_a == LAMP_RED) || (light_b == LAMP_RED)); // R9
  AST_LEGAL_CODES: assert property (@(posedge clk) disable iff (rst)
    (light_a != 2'b11) && (light_b != 2'b11)); // R9
  AST_A_STAYS_GREEN: assert property (@(posedge clk) disable iff (rst)
    (light_a == LAMP_GREEN && sense_a) |=> light_a == LAMP_GREEN); // R2
  AST_A_TO_YELLOW: assert property (@(posedge clk) disable iff (rst)
    (light_a == LAMP_GREEN && !sense_a) |=> light_a == LAMP_YELLOW); // R3
endmodule

// File: tb/test_traffic_parade_ctrl.sv
module test_traffic_parade_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sense_a = 1'b0, sense_b = 1'b0, parade_req = 1'b0, parade_end = 1'b0;
  logic [1:0] light_a, light_b;

  int n_cmp = 0;
  int n_bad = 0;

  // reference model: phase 0..3 = A green, A yellow, B green, B yellow
  int  m_phase = 0;
  bit  m_parade = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  traffic_parade_ctrl i_traffic_parade_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sense_a    (sense_a),
    .sense_b    (sense_b),
    .parade_req (parade_req),
    .parade_end (parade_end),
    .light_a    (light_a),
    .light_b    (light_b)
  );

  function automatic logic [1:0] exp_a(int ph);
    case (ph)
      0: return 2'b00;
      1: return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [1:0] exp_b(int ph);
    case (ph)
      2: return 2'b00;
      3: return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  task automatic check2(string req, logic [1:0] act, logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model steps at the edge, sample at next negedge
  task automatic step(string req, bit r, bit a, bit b, bit p, bit e);
    int nxt;
    rst = r; sense_a = a; sense_b = b; parade_req = p; parade_end = e;
    @(posedge clk);
    if (r) begin
      nxt = 0;
      m_parade = 1'b0;
    end else begin
      case (m_phase)
        0: nxt = a ? 0 : 1;
        1: nxt = 2;
        2: nxt = (m_parade || b) ? 2 : 3;
        default: nxt = 0;
      endcase
      if (e)      m_parade = 1'b0;
      else if (p) m_parade = 1'b1;
    end
    m_phase = nxt;
    @(negedge clk);
    check2({req, " light_a"}, light_a, exp_a(m_phase));
    check2({req, " light_b"}, light_b, exp_b(m_phase));
  endtask

  task automatic t_reset;
    step("R1", 1, 1, 1, 1, 0);
    step("R1", 1, 0, 0, 0, 0);
    check2("R1 reset A green", light_a, 2'b00);
    check2("R1 reset B red", light_b, 2'b10);
  endtask

  task automatic t_a_holds;
    for (int i = 0; i < 4; i++) step("R2", 0, 1, 1, 0, 0);
    check2("R2 A still green", light_a, 2'b00);
  endtask

  task automatic t_full_cycle;
    step("R3", 0, 0, 0, 0, 0);
    check2("R3 A yellow", light_a, 2'b01);
    step("R4", 0, 1, 0, 0, 0);
    check2("R4 B green", light_b, 2'b00);
    step("R5", 0, 0, 1, 0, 0);
    check2("R5 B held by sensor", light_b, 2'b00);
    step("R6", 0, 0, 0, 0, 0);
    check2("R6 B yellow", light_b, 2'b01);
    step("R6", 0, 0, 1, 0, 0);
    check2("R6 back to A green", light_a, 2'b00);
  endtask

  task automatic t_parade;
    step("R7", 0, 1, 0, 1, 0);           // request while A green
    step("R3", 0, 0, 0, 0, 0);           // A yellow
    step("R4", 0, 0, 0, 0, 0);           // B green
    for (int i = 0; i < 5; i++) step("R5", 0, 0, 0, 0, 0);
    check2("R5 parade keeps B green", light_b, 2'b00);
    step("R7", 0, 0, 0, 0, 1);           // release: mode off after this edge
    check2("R7 one more green cycle", light_b, 2'b00);
    step("R7", 0, 0, 0, 0, 0);
    check2("R7 B yellow after release", light_b, 2'b01);
    step("R6", 0, 1, 0, 0, 0);
  endtask

  task automatic t_priority;
    step("R8", 0, 0, 0, 1, 1);           // both: mode stays off; A -> yellow
    step("R4", 0, 0, 0, 0, 0);           // B green
    step("R8", 0, 0, 0, 0, 0);           // no parade, no B traffic -> yellow
    check2("R8 end wins from normal", light_b, 2'b01);
    step("R6", 0, 1, 0, 1, 0);           // enter parade, A green
    step("R3", 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 1);           // both while in parade: leave
    step("R8", 0, 0, 0, 0, 0);
    check2("R8 end wins from parade", light_b, 2'b01);
  endtask

  task automatic t_random;
    for (int i = 0; i < 3000; i++) begin
      int rv;
      rv = $urandom;
      step("R10", (rv % 251) == 0, rv[0], rv[1], (rv[6:2] == 0), (rv[11:7] == 0));
      n_cmp++;
      if (light_a != 2'b10 && light_b != 2'b10) begin
        n_bad++;
        $display("FAIL R9: actual %b/%b expected one side 10", light_a, light_b);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_a_holds();
    t_full_cycle();
    t_parade();
    t_priority();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule